// File: doc/BRIEF.md
# Multi-Lane Table-Driven Automaton Scanner

This block runs a compiled deterministic automaton over a byte stream that arrives in fixed-size chunks. The next-state function sits in a single loadable cell memory. The memory has one row per state and one column per byte value. Each cell holds the next state and a flag that marks that next state as accepting. The cost per byte is one cell lookup, whatever the number of patterns compiled into the automaton.

Each accepted chunk goes to one of several scanning lanes. A lane holds its own current state and starts every chunk in state 0, and lanes never exchange state. All lanes share the cell memory through a round-robin arbiter that grants one lookup per cycle. When a lookup returns a cell with the accepting flag set, the block reports a match one cycle later, and the lane goes on scanning the same chunk.

Software fills the cell memory through a write port while no lane is scanning. A match that crosses from one chunk into the next is not detected.

Top module: `mlane_dfa_scanner`

## Requirements
- R1: After a synchronous active-low reset, every lane is idle, `chunk_ready` is 1 and `match_valid` is 0.
- R2: `chunk_ready` is 1 exactly when at least one lane is idle. A chunk is taken on a clock edge where `chunk_valid` and `chunk_ready` are both 1, and it goes to the lowest-numbered idle lane. Byte k of the chunk is `chunk_data[8k+7:8k]`, and byte 0 is scanned first.
- R3: A lane starts each chunk in state 0. On each grant it consumes its next byte b and moves from state s to the cell at address s*256+b, so every byte costs exactly one lookup.
- R4: When the looked-up cell has its accepting flag set, `match_valid` is 1 in the following cycle. With it, `match_lane` gives the lane, `match_offset` gives the 0-based position of the consumed byte within its chunk, and `match_state` gives the new state. The lane keeps scanning after a match.
- R5: At most one lookup is granted per cycle. After lane g is granted, the next grant goes to the first busy lane after g in cyclic order. After reset, lane 0 has the highest priority.
- R6: Lanes do not influence each other. The state a lane reaches at the end of one chunk has no effect on the next chunk it scans.
- R7: A write on the table port stores next state and accepting flag into cell `tbl_wr_state`*256+`tbl_wr_sym` on a clock edge where all lanes are idle. A write on an edge where any lane is busy is ignored.
- R8: A lane becomes idle right after its CHUNK_LEN-th lookup, and it can then accept a new chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_wr_en | input | 1 | Cell write strobe |
| tbl_wr_state | input | STATE_W | Row (current state) of the cell to write |
| tbl_wr_sym | input | 8 | Column (byte value) of the cell to write |
| tbl_wr_next | input | STATE_W | Next state to store |
| tbl_wr_acc | input | 1 | Accepting flag to store |
| chunk_valid | input | 1 | Chunk offered |
| chunk_ready | output | 1 | A lane is free to take a chunk |
| chunk_data | input | CHUNK_LEN*8 | Chunk bytes, byte 0 in the low bits |
| match_valid | output | 1 | Match report valid |
| match_lane | output | LANE_W | Lane that matched |
| match_offset | output | OFF_W | Byte position within the chunk |
| match_state | output | STATE_W | Accepting state that was reached |

## Verification
The bench builds the block with three lanes, four states and six-byte chunks. With a lane count that is not a power of two, the round-robin wrap and the lowest-idle choice are exercised on a pointer that skips unused codes. The small state count lets the bench load every one of the 1024 cells. The short chunks let all lanes fill up within a few cycles, so `chunk_ready` stalls and a chunk waits for the first lane to finish. The tests include a match at the last position of a chunk, an automaton left half-way at a chunk boundary, and table writes issued both during a scan and after it.

// File: rtl/mlds_pkg.sv
// Shared constants of the multi-lane automaton scanner.
// Assumes byte-wide input symbols.
package mlds_pkg;
    localparam int SYM_W    = 8;
    localparam int ALPHABET = 1 << SYM_W;
endpackage

// File: rtl/mlds_cell_table.sv
// Next-state cell memory: one row per state, one column per byte value.
// Each cell is {accepting flag, next state}. The read is combinational.
// Assumes the caller gates writes. Contents are not reset.
module mlds_cell_table
    import mlds_pkg::*;
#(
    parameter int STATE_W = 3
) (
    input  logic               clk,
    input  logic               we,
    input  logic [STATE_W-1:0] wr_state,
    input  logic [SYM_W-1:0]   wr_sym,
    input  logic [STATE_W-1:0] wr_next,
    input  logic               wr_acc,
    input  logic [STATE_W-1:0] rd_state,
    input  logic [SYM_W-1:0]   rd_sym,
    output logic [STATE_W-1:0] rd_next,
    output logic               rd_acc
);
    localparam int ADDR_W  = STATE_W + SYM_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int ENTRY_W = STATE_W + 1;

    logic [ENTRY_W-1:0] cells [DEPTH];

    // store one cell when the gated strobe is set
    always_ff @(posedge clk) begin
        if (we) begin
            cells[{wr_state, wr_sym}] <= {wr_acc, wr_next};
        end
    end

    // look up the cell of the granted lane
    assign {rd_acc, rd_next} = cells[{rd_state, rd_sym}];
endmodule

// File: rtl/mlds_rr_arb.sv
// Round-robin arbiter: grants at most one requester per cycle, starting
// the search just after the last granted index. Lane 0 goes first after reset.
// Assumes N >= 2.
module mlds_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);
    logic [IDX_W-1:0] last_q;

    // pick the first requester after the last winner in cyclic order
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = 1; i <= N; i++) begin
            if (!grant_any && req[(int'(last_q) + i) % N]) begin
                grant_any                     = 1'b1;
                grant[(int'(last_q) + i) % N] = 1'b1;
                grant_idx                     = IDX_W'((int'(last_q) + i) % N);
            end
        end
    end

    // remember the winner so that it has the lowest priority next time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (grant_any) begin
            last_q <= grant_idx;
        end
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R5
    grant_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any && ($countones(req) > 1) && req[grant_idx]) |=> (grant_idx != $past(grant_idx)) || !req[grant_idx] || ($countones(req) == 1));
endmodule

// File: rtl/mlds_lane.sv
// One scanning lane: holds a chunk, its byte position and its current
// automaton state. It advances one byte per grant and turns idle after
// the last byte. Assumes load is only raised while idle and grant only
// while busy.
module mlds_lane
    import mlds_pkg::*;
#(
    parameter int CHUNK_LEN = 8,
    parameter int STATE_W   = 3,
    parameter int OFF_W     = $clog2(CHUNK_LEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [CHUNK_LEN*SYM_W-1:0] chunk,
    input  logic                       grant,
    input  logic [STATE_W-1:0]         next_state,
    output logic                       busy,
    output logic [STATE_W-1:0]         cur_state,
    output logic [SYM_W-1:0]           cur_sym,
    output logic [OFF_W-1:0]           pos
);
    localparam int DATA_W = CHUNK_LEN * SYM_W;
    localparam int LAST   = CHUNK_LEN - 1;

    logic [DATA_W-1:0] bytes_q;

    // take a new chunk, or step one byte on each grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cur_state <= '0;
            pos       <= '0;
            bytes_q   <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            cur_state <= '0;
            pos       <= '0;
            bytes_q   <= chunk;
        end else if (grant) begin
            cur_state <= next_state;
            pos       <= pos + 1'b1;
            bytes_q   <= bytes_q >> SYM_W;
            if (pos == OFF_W'(LAST)) begin
                busy <= 1'b0;
            end
        end
    end

    // the byte to consume next is always in the low bits
    assign cur_sym = bytes_q[SYM_W-1:0];

    // R3
    start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_state == '0) && (pos == '0) && busy);

    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

    // R5
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy);

    // R8
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (pos == OFF_W'(LAST))) |=> !busy);
endmodule

// File: rtl/mlane_dfa_scanner.sv
// Multi-lane table-driven automaton scanner. Chunks go to the lowest idle
// lane, and lanes share the cell memory through a round-robin arbiter.
// A lookup whose cell is flagged accepting raises a match report one cycle
// later. Table writes go through only while every lane is idle.
// Assumes LANES >= 2, CHUNK_LEN >= 2, and that the table is fully loaded
// before the first chunk.
module mlane_dfa_scanner
    import mlds_pkg::*;
#(
    parameter  int LANES     = 4,
    parameter  int STATE_W   = 3,
    parameter  int CHUNK_LEN = 8,
    localparam int LANE_W    = $clog2(LANES),
    localparam int OFF_W     = $clog2(CHUNK_LEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tbl_wr_en,
    input  logic [STATE_W-1:0]         tbl_wr_state,
    input  logic [SYM_W-1:0]           tbl_wr_sym,
    input  logic [STATE_W-1:0]         tbl_wr_next,
    input  logic                       tbl_wr_acc,
    input  logic                       chunk_valid,
    output logic                       chunk_ready,
    input  logic [CHUNK_LEN*SYM_W-1:0] chunk_data,
    output logic                       match_valid,
    output logic [LANE_W-1:0]          match_lane,
    output logic [OFF_W-1:0]           match_offset,
    output logic [STATE_W-1:0]         match_state
);
    logic [LANES-1:0]   busy;
    logic [LANES-1:0]   load;
    logic [LANES-1:0]   grant;
    logic [LANE_W-1:0]  grant_idx;
    logic               grant_any;
    logic               idle_found;
    logic [STATE_W-1:0] lane_state [LANES];
    logic [SYM_W-1:0]   lane_sym   [LANES];
    logic [OFF_W-1:0]   lane_pos   [LANES];
    logic [STATE_W-1:0] rd_next;
    logic               rd_acc;
    logic               tbl_we;

    // a chunk can be taken whenever some lane is idle
    assign chunk_ready = ~&busy;

    // steer an offered chunk to the lowest-numbered idle lane
    always_comb begin
        load       = '0;
        idle_found = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (!idle_found && !busy[l]) begin
                load[l]    = chunk_valid;
                idle_found = 1'b1;
            end
        end
    end

    // table writes only pass while no lane is scanning
    assign tbl_we = tbl_wr_en && (busy == '0);

    mlds_rr_arb #(
        .N     (LANES),
        .IDX_W (LANE_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (busy),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    mlds_cell_table #(
        .STATE_W (STATE_W)
    ) u_table (
        .clk      (clk),
        .we       (tbl_we),
        .wr_state (tbl_wr_state),
        .wr_sym   (tbl_wr_sym),
        .wr_next  (tbl_wr_next),
        .wr_acc   (tbl_wr_acc),
        .rd_state (lane_state[grant_idx]),
        .rd_sym   (lane_sym[grant_idx]),
        .rd_next  (rd_next),
        .rd_acc   (rd_acc)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mlds_lane #(
            .CHUNK_LEN (CHUNK_LEN),
            .STATE_W   (STATE_W),
            .OFF_W     (OFF_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load[g]),
            .chunk      (chunk_data),
            .grant      (grant[g]),
            .next_state (rd_next),
            .busy       (busy[g]),
            .cur_state  (lane_state[g]),
            .cur_sym    (lane_sym[g]),
            .pos        (lane_pos[g])
        );
    end

    // register a match report for every accepting lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid  <= 1'b0;
            match_lane   <= '0;
            match_offset <= '0;
            match_state  <= '0;
        end else begin
            match_valid <= grant_any && rd_acc;
            if (grant_any) begin
                match_lane   <= grant_idx;
                match_offset <= lane_pos[grant_idx];
                match_state  <= rd_next;
            end
        end
    end

    // R2
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && chunk_ready) |=> $countones(busy) >= $past($countones(busy)));

    // R4
    match_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(grant_any));

    // R4
    match_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> (int'(match_offset) < CHUNK_LEN) && (int'(match_lane) < LANES));
endmodule

// File: tb/mlane_dfa_scanner_bench.sv
// Bench: a behavioural reference model that runs alongside the design and is
// compared with it every cycle, plus scenario checks with known match counts.
module mlane_dfa_scanner_bench;
    localparam int LANES = 3;
    localparam int SW    = 2;
    localparam int CL    = 6;
    localparam int NS    = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_wr_en = 1'b0;
    logic [SW-1:0] tbl_wr_state = '0;
    logic [7:0]    tbl_wr_sym = '0;
    logic [SW-1:0] tbl_wr_next = '0;
    logic          tbl_wr_acc = 1'b0;
    logic          chunk_valid = 1'b0;
    logic          chunk_ready;
    logic [CL*8-1:0] chunk_data = '0;
    logic          match_valid;
    logic [1:0]    match_lane;
    logic [2:0]    match_offset;
    logic [SW-1:0] match_state;

    int n_checks = 0;
    int n_fails  = 0;
    int dut_matches = 0;
    int last_lane = -1;
    int last_off  = -1;

    always #4 clk = ~clk;

    mlane_dfa_scanner #(
        .LANES     (LANES),
        .STATE_W   (SW),
        .CHUNK_LEN (CL)
    ) u_mlane_dfa_scanner (
        .clk          (clk),
        .rst_n        (rst_n),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_wr_state (tbl_wr_state),
        .tbl_wr_sym   (tbl_wr_sym),
        .tbl_wr_next  (tbl_wr_next),
        .tbl_wr_acc   (tbl_wr_acc),
        .chunk_valid  (chunk_valid),
        .chunk_ready  (chunk_ready),
        .chunk_data   (chunk_data),
        .match_valid  (match_valid),
        .match_lane   (match_lane),
        .match_offset (match_offset),
        .match_state  (match_state)
    );

    // ---------------- reference model ----------------
    int  m_next [NS][256];
    bit  m_acc  [NS][256];
    bit  m_busy [LANES];
    int  m_state[LANES];
    int  m_pos  [LANES];
    int  m_data [LANES][CL];
    int  m_last;
    bit  pre_busy[LANES];
    bit  any_busy, any_idle, found;
    int  g, b, nx, lo;
    bit  e_mv;
    int  e_lane, e_off, e_state;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                m_busy[l] = 0; m_state[l] = 0; m_pos[l] = 0;
            end
            m_last = LANES - 1;
            e_mv = 0;
        end else begin
            any_busy = 0; any_idle = 0; lo = -1;
            for (int l = 0; l < LANES; l++) begin
                pre_busy[l] = m_busy[l];
                if (m_busy[l]) any_busy = 1;
                else begin
                    any_idle = 1;
                    if (lo < 0) lo = l;
                end
            end
            found = 0; e_mv = 0;
            for (int i = 1; i <= LANES; i++) begin
                g = (m_last + i) % LANES;
                if (!found && pre_busy[g]) begin
                    found = 1;
                    b  = m_data[g][m_pos[g]];
                    nx = m_next[m_state[g]][b];
                    e_mv = m_acc[m_state[g]][b];
                    e_lane = g; e_off = m_pos[g]; e_state = nx;
                    m_state[g] = nx;
                    if (m_pos[g] == CL - 1) m_busy[g] = 0;
                    m_pos[g] = m_pos[g] + 1;
                    m_last = g;
                end
            end
            if (chunk_valid && any_idle) begin
                m_busy[lo] = 1; m_state[lo] = 0; m_pos[lo] = 0;
                for (int k = 0; k < CL; k++) m_data[lo][k] = int'(chunk_data[8*k +: 8]);
            end
            if (tbl_wr_en && !any_busy) begin
                m_next[tbl_wr_state][tbl_wr_sym] = int'(tbl_wr_next);
                m_acc[tbl_wr_state][tbl_wr_sym]  = tbl_wr_acc;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_ready;
            e_ready = 0;
            for (int l = 0; l < LANES; l++) if (!m_busy[l]) e_ready = 1;
            chk("R2 R8 chunk_ready", int'(chunk_ready), int'(e_ready));
            chk("R4 match_valid", int'(match_valid), int'(e_mv));
            if (match_valid && e_mv) begin
                chk("R5 match_lane", int'(match_lane), e_lane);
                chk("R4 match_offset", int'(match_offset), e_off);
                chk("R3 match_state", int'(match_state), e_state);
            end
            if (match_valid) begin
                dut_matches++;
                last_lane = int'(match_lane);
                last_off  = int'(match_offset);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    // automaton finding "abc": state = length of matched prefix, 3 accepts
    function automatic int abc_next(input int s, input int c);
        if (c == 8'h61) return 1;
        if (s == 1 && c == 8'h62) return 2;
        if (s == 2 && c == 8'h63) return 3;
        return 0;
    endfunction

    function automatic logic [CL*8-1:0] pk(input string s);
        logic [CL*8-1:0] v;
        for (int i = 0; i < CL; i++) v[8*i +: 8] = s[i];
        return v;
    endfunction

    task automatic wr_cell(input int s, input int c, input int n, input bit a);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_state = SW'(s); tbl_wr_sym = 8'(c);
        tbl_wr_next = SW'(n); tbl_wr_acc = a;
        @(negedge clk);
        tbl_wr_en = 0;
    endtask

    task automatic send(input string s);
        @(negedge clk);
        chunk_valid = 1; chunk_data = pk(s);
        while (!chunk_ready) @(negedge clk);
        @(negedge clk);
        chunk_valid = 0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 chunk_ready after reset", int'(chunk_ready), 1);
        chk("R1 match_valid after reset", int'(match_valid), 0);

        // R7: load every cell while idle
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 256; c++)
                wr_cell(s, c, abc_next(s, c), abc_next(s, c) == 3);

        // R4 R3: single chunk, one match at offset 3 in lane 0
        base = dut_matches;
        send("xabcab");
        settle();
        chk("R4 match count single chunk", dut_matches - base, 1);
        chk("R4 match offset", last_off, 3);
        chk("R2 lowest idle lane", last_lane, 0);

        // R6: lane 0 ended in state 2 ("ab"); next chunk starts with 'c'
        base = dut_matches;
        send("cxxxxx");
        settle();
        chk("R6 no state carried across chunks", dut_matches - base, 0);

        // R2 R5 R8: fill all lanes, a fourth chunk waits for a free lane
        base = dut_matches;
        send("abcabc");
        send("aabcxx");
        send("cccccc");
        send("bcabcq");
        settle();
        chk("R5 match count interleaved lanes", dut_matches - base, 4);
        chk("R8 lanes idle again", int'(chunk_ready), 1);
        chk("R4 match at last offset", last_off, 4);

        // R7: write during a scan is ignored
        send("aaaaaa");
        wr_cell(0, 8'h7a, 3, 1);
        settle();
        base = dut_matches;
        send("zzzzzz");
        settle();
        chk("R7 write during scan ignored", dut_matches - base, 0);

        // R7: the same write while idle takes effect
        wr_cell(0, 8'h7a, 3, 1);
        base = dut_matches;
        send("zzzzzz");
        settle();
        chk("R7 write while idle applied", dut_matches - base, 3);
        chk("R4 last match offset", last_off, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule